// File: doc/BRIEF.md
# Not-Recently-Used Way Selector

This block tracks replacement state for one set of an eight-way cache. Each way has a single used flag. Every access marks the accessed way as used. If that access would leave every way marked, the whole field is wiped and only the way just accessed stays marked. As a result, at least one way is always unmarked.

When the cache needs to evict a line, it raises a victim request together with a 3-bit start position taken from address bits. The block scans the flags circularly from that position and returns the first unmarked way. Starting the scan at an address-dependent point spreads replacements across the set, so the lowest-numbered free way is not always the one chosen. The victim output is combinational. When an access and a request arrive in the same cycle, the victim is chosen from the flags as they were before that access.

Top module: `nru_selector`

## Requirements
- R1: After reset all used flags are clear, so a victim request with start position s returns way s.
- R2: An access that does not fill the field sets the accessed way's flag and leaves every other flag unchanged.
- R3: An access that would set the last clear flag leaves exactly one flag set, that of the accessed way.
- R4: An access to a way whose flag is already set, while another flag is still clear, leaves the field unchanged.
- R5: The victim is the first way with a clear flag, scanning in the order s, s+1, … up to way 7, then wrapping to way 0, where s is the start position.
- R6: When an access and a victim request occur in the same cycle, the victim is computed from the flags before that access updates them.
- R7: In a cycle without an access the flags hold their value, whether or not a victim is requested.
- R8: `victim_valid` is high exactly when `victim_req` is high, because a clear flag always exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| access_en | input | 1 | Marks an access in this cycle |
| access_way | input | 3 | Way being accessed |
| victim_req | input | 1 | Requests a replacement choice |
| scan_start | input | 3 | Way at which the circular scan begins |
| victim_way | output | 3 | Chosen way to replace |
| victim_valid | output | 1 | Victim output is meaningful |

## Verification
The flags are filled one way at a time while scans start from several positions, including positions that must wrap past way 7. This separates a circular scan from a plain scan upward from way 0, and it reads out the field's state through the victim port. A repeated access to a way that is already marked separates R4 from a design that toggles or recounts the flag. The access that sets the final flag is followed by scans from the kept way, from the way below it and from way 7, which separates "keep only the accessed way" from "clear everything" or "keep everything". Same-cycle access and request vectors show whether the victim comes from the old state or the new one.

// File: rtl/nru_pkg.sv
package nru_pkg;
  parameter int unsigned NRU_WAYS  = 8;
  parameter int unsigned NRU_IDX_W = $clog2(NRU_WAYS);

  // Single-hot mask with bit idx set when en is high.
  function automatic logic [NRU_WAYS-1:0] way_mask(input logic en,
                                                   input logic [NRU_IDX_W-1:0] idx);
    logic [NRU_WAYS-1:0] m;
    m      = '0;
    m[idx] = en;
    return m;
  endfunction
endpackage

// File: rtl/nru_used_bits.sv
module nru_used_bits
  import nru_pkg::*;
#(
  parameter int unsigned WAYS  = NRU_WAYS,
  localparam int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_en,
  input  logic [IDX_W-1:0] access_way,
  output logic [WAYS-1:0]  used_q,
  output logic             sat_evt
);
  logic [WAYS-1:0] touch_mask;
  logic [WAYS-1:0] merged;
  logic [WAYS-1:0] used_d;

  always_comb begin
    touch_mask             = '0;
    touch_mask[access_way] = access_en;
  end

  assign merged  = used_q | touch_mask;
  assign sat_evt = access_en && (&merged);
  assign used_d  = sat_evt ? touch_mask : merged;

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  // R2: accessed way is marked one cycle later
  a_r2_marks_access: assert property (@(posedge clk) disable iff (!rst_n)
    access_en |=> used_q[$past(access_way)]);

  // R3: after a saturating access exactly one flag remains
  a_r3_single_after_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> ($countones(used_q) == 1));

  // R3: the field is never completely full
  a_r3_never_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(&used_q));

  // R7: no access, no change
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !access_en |=> $stable(used_q));
endmodule

// File: rtl/nru_scan.sv
module nru_scan #(
  parameter int unsigned WAYS  = 8,
  localparam int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  used,
  input  logic [IDX_W-1:0] start,
  output logic [IDX_W-1:0] pick,
  output logic             any_free
);
  logic [WAYS-1:0]  rot_free;
  logic [IDX_W-1:0] offset;

  // Rotate so that bit 0 of rot_free corresponds to the start way.
  for (genvar g = 0; g < WAYS; g++) begin : g_rot
    logic [IDX_W-1:0] src;
    assign src         = start + IDX_W'(g);
    assign rot_free[g] = ~used[src];
  end

  always_comb begin
    offset = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (rot_free[i]) offset = IDX_W'(i);
    end
  end

  assign any_free = |rot_free;
  assign pick     = start + offset;
endmodule

// File: rtl/nru_selector.sv
module nru_selector
  import nru_pkg::*;
#(
  parameter int unsigned WAYS  = NRU_WAYS,
  localparam int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_en,
  input  logic [IDX_W-1:0] access_way,
  input  logic             victim_req,
  input  logic [IDX_W-1:0] scan_start,
  output logic [IDX_W-1:0] victim_way,
  output logic             victim_valid
);
  logic [WAYS-1:0]  used_q;
  logic             sat_evt;
  logic             any_free;
  logic [IDX_W-1:0] pick;

  nru_used_bits #(.WAYS(WAYS)) i_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .access_en  (access_en),
    .access_way (access_way),
    .used_q     (used_q),
    .sat_evt    (sat_evt)
  );

  // Scan reads the registered flags, so a same-cycle access is not seen (R6).
  nru_scan #(.WAYS(WAYS)) i_scan (
    .used     (used_q),
    .start    (scan_start),
    .pick     (pick),
    .any_free (any_free)
  );

  assign victim_way   = pick;
  assign victim_valid = victim_req && any_free;

  // R5: the chosen way is always an unmarked one
  a_r5_pick_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    victim_req |-> !used_q[victim_way]);

  // R8: a victim is offered on every request
  a_r8_valid_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid == victim_req);

  // R3: a wipe keeps the accessed way marked
  a_r3_keeps_accessor: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> used_q[$past(access_way)]);
endmodule

// File: tb/test_nru_selector.sv
`timescale 1ns/1ps
module test_nru_selector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       access_en = 1'b0;
  logic [2:0] access_way = '0;
  logic       victim_req = 1'b0;
  logic [2:0] scan_start = '0;
  logic [2:0] victim_way;
  logic       victim_valid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nru_selector i_nru_selector (
    .clk(clk), .rst_n(rst_n), .access_en(access_en), .access_way(access_way),
    .victim_req(victim_req), .scan_start(scan_start),
    .victim_way(victim_way), .victim_valid(victim_valid)
  );

  // {access_en, access_way, victim_req, scan_start, exp_valid, exp_way}
  localparam int NV = 26;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0,3'd0,1'b1,3'd5,1'b1,3'd5}, // R1 empty field
    {1'b1,3'd5,1'b1,3'd5,1'b1,3'd5}, // R6 old state used
    {1'b0,3'd0,1'b1,3'd5,1'b1,3'd6}, // R2 way5 marked
    {1'b1,3'd6,1'b0,3'd0,1'b0,3'd0}, // R8 no request
    {1'b0,3'd0,1'b1,3'd5,1'b1,3'd7}, // R5
    {1'b1,3'd7,1'b0,3'd0,1'b0,3'd0},
    {1'b0,3'd0,1'b1,3'd5,1'b1,3'd0}, // R5 wrap to 0
    {1'b1,3'd0,1'b0,3'd0,1'b0,3'd0},
    {1'b1,3'd1,1'b0,3'd0,1'b0,3'd0},
    {1'b1,3'd2,1'b0,3'd0,1'b0,3'd0},
    {1'b0,3'd0,1'b1,3'd0,1'b1,3'd3}, // R5
    {1'b0,3'd0,1'b1,3'd6,1'b1,3'd3}, // R5 wrap
    {1'b0,3'd0,1'b1,3'd4,1'b1,3'd4}, // R5 start free
    {1'b1,3'd3,1'b0,3'd0,1'b0,3'd0},
    {1'b0,3'd0,1'b1,3'd0,1'b1,3'd4}, // R2 one left
    {1'b0,3'd0,1'b1,3'd5,1'b1,3'd4}, // R5 wrap
    {1'b1,3'd3,1'b0,3'd0,1'b0,3'd0}, // R4 repeat
    {1'b0,3'd0,1'b1,3'd7,1'b1,3'd4}, // R4 unchanged
    {1'b1,3'd4,1'b0,3'd0,1'b0,3'd0}, // R3 saturating
    {1'b0,3'd0,1'b1,3'd4,1'b1,3'd5}, // R3 kept way 4
    {1'b0,3'd0,1'b1,3'd3,1'b1,3'd3}, // R3 others clear
    {1'b0,3'd0,1'b1,3'd7,1'b1,3'd7}, // R3
    {1'b1,3'd4,1'b1,3'd4,1'b1,3'd5}, // R4 R6
    {1'b0,3'd0,1'b1,3'd4,1'b1,3'd5}, // R4 still only way4
    {1'b0,3'd0,1'b0,3'd1,1'b0,3'd0}, // R7 idle
    {1'b0,3'd0,1'b1,3'd0,1'b1,3'd0}  // R7 state held
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic a, input logic [2:0] w, input logic r,
                       input logic [2:0] s);
    @(negedge clk);
    access_en = a; access_way = w; victim_req = r; scan_start = s;
    #1;
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][11], VEC[i][10:8], VEC[i][7], VEC[i][6:4]);
      chk("R8 valid", int'(victim_valid), int'(VEC[i][3]));
      if (VEC[i][3]) chk("R5 victim", int'(victim_way), int'(VEC[i][2:0]));
    end
    // R1: reset mid-run clears the field
    apply(1'b1, 3'd0, 1'b0, 3'd0);
    apply(1'b1, 3'd1, 1'b0, 3'd0);
    @(negedge clk) rst_n = 1'b0; access_en = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    apply(1'b0, 3'd0, 1'b1, 3'd0);
    chk("R1 reset clears", int'(victim_way), 0);
    // R2: only the accessed way changes
    apply(1'b1, 3'd2, 1'b0, 3'd0);
    apply(1'b0, 3'd0, 1'b1, 3'd2);
    chk("R2 way2 marked", int'(victim_way), 3);
    apply(1'b0, 3'd0, 1'b1, 3'd1);
    chk("R2 way1 untouched", int'(victim_way), 1);
    apply(1'b0, 3'd0, 1'b1, 3'd3);
    chk("R2 way3 untouched", int'(victim_way), 3);
    apply(1'b0, 3'd0, 1'b0, 3'd0);
    chk("R8 idle valid", int'(victim_valid), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule